// File: doc/BRIEF.md
# Shift-Register Upset Detection Harness

This block is a self-test circuit placed inside a programmable device to reveal radiation-induced upsets in its flip-flops and in the configuration that wires them. A counter held in three copies, majority-voted bit by bit on every clock, produces a serial test stream and a wrap heartbeat on `trig`. The same stream is shifted into four identical shift registers. The serial outputs of each neighbouring pair of registers are compared. Any difference, once the registers have refilled after a clear, sets a sticky pair flag.

A small independent timer checks the counter's heartbeat. If the voted counter wraps at a cycle where the timer does not, or the timer wraps and the counter does not, a sticky heartbeat failure is recorded. The three pair flags and the heartbeat failure are gathered into a registered 4-bit status code. An outside monitor reads the first failure as the first time the code leaves zero, and the last failure as the code reaching all ones.

Two injection inputs let a test corrupt one counter copy, or the bit entering one register, for a single clock. These inputs model upsets.

Top module: `seuShiftMonitor`

## Requirements
- R1: After reset (`rstN` low) or a clock with `clr` high, `trig`, `pairErr` and `statusCode` are all zero. An injection applied in the same clock as `clr` has no effect.
- R2: The three counter copies are voted 2-of-3 per bit, and the voted value plus one is written into all copies. Corrupting any single copy for one clock therefore changes neither the heartbeat timing nor the test stream.
- R3: `trig` is high for exactly one clock. It rises on the edge after the voted count reaches all ones, which gives one pulse every 2^CNT_W clocks; the first pulse comes 2^CNT_W edges after the clearing edge.
- R4: Every register shifts in the same bit each clock, namely bit DATA_TAP of the voted count. With no injection, no pair flag ever sets.
- R5: Flag `pairErr[k]` compares the serial outputs of register k and register k+1. If the bit entering one register is inverted at edge E, the flags concerned set at edge E+16. Comparisons are ignored until 16 clocks have passed since the clear.
- R6: A set pair flag or heartbeat failure stays set until reset or `clr`.
- R7: If the voted count is knocked off its sequence (two copies corrupted at once), the mismatch against the independent timer sets the heartbeat failure, and the pair flags are unaffected.
- R8: `statusCode` is registered one clock after the sticky flags. Its layout is: bit 0 heartbeat failure, bit 1 `pairErr[0]`, bit 2 `pairErr[1]`, bit 3 `pairErr[2]`. All ones means every monitored signal has failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of counters, registers and flags |
| hitCopy | input | 3 | Invert bit 0 of counter copy k on this clock |
| hitReg | input | 4 | Invert the bit entering shift register k on this clock |
| trig | output | 1 | Heartbeat pulse on counter wrap |
| pairErr | output | 3 | Sticky mismatch flags of neighbouring register pairs |
| statusCode | output | 4 | Registered status code: heartbeat failure and three pair flags |

## Verification
Each result has a fixed delay. `trig` follows the voted count by one edge. A pair flag follows a register injection by sixteen edges. `statusCode` lags the flags by one further edge. The bench's behavioural model moves its own queues and counters on each rising edge and compares all three outputs at every falling edge. Directed checks sample one falling edge before and one after each due edge, so a result that arrives early or late is reported.

// File: rtl/seuMonPkg.sv
package seuMonPkg;

  // Per-clock strobes from the control half to the datapath half.
  typedef struct packed {
    logic clear;    // synchronous clear request
    logic cmpEn;    // registers refilled, comparisons valid
    logic dataBit;  // serial test bit for all registers
    logic trigBad;  // heartbeat disagrees with independent timer
  } strobe_t;

endpackage

// File: rtl/seuMonCtrl.sv
module seuMonCtrl
  import seuMonPkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SR_LEN   = 16,
  parameter int DATA_TAP = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clr,
  input  logic [2:0] hitCopy,
  output logic       trig,
  output strobe_t    strb
);

  localparam int MASK_W = $clog2(SR_LEN + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [MASK_W-1:0] MASK_DONE = MASK_W'(SR_LEN);

  logic [CNT_W-1:0]  copyQ [3];
  logic [CNT_W-1:0]  voted;
  logic [CNT_W-1:0]  nextVal;
  logic [CNT_W-1:0]  monQ;
  logic [MASK_W-1:0] maskQ;

  // Bitwise 2-of-3 vote of the counter copies.
  always_comb begin
    voted   = (copyQ[0] & copyQ[1]) | (copyQ[0] & copyQ[2]) | (copyQ[1] & copyQ[2]);
    nextVal = voted + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 3; k++) copyQ[k] <= '0;
      monQ  <= '0;
      maskQ <= '0;
      trig  <= 1'b0;
    end else if (clr) begin
      for (int k = 0; k < 3; k++) copyQ[k] <= '0;
      monQ  <= '0;
      maskQ <= '0;
      trig  <= 1'b0;
    end else begin
      for (int k = 0; k < 3; k++)
        copyQ[k] <= nextVal ^ {{(CNT_W-1){1'b0}}, hitCopy[k]};
      monQ <= monQ + CNT_W'(1);
      if (maskQ != MASK_DONE) maskQ <= maskQ + MASK_W'(1);
      trig <= (voted == CNT_MAX);
    end
  end

  always_comb begin
    strb.clear   = clr;
    strb.cmpEn   = (maskQ == MASK_DONE);
    strb.dataBit = voted[DATA_TAP];
    strb.trigBad = (voted == CNT_MAX) != (monQ == CNT_MAX);
  end

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> !trig);                                                   // R3

  AST_COPIES_HEAL: assert property (@(posedge clk) disable iff (!rstN)
    (hitCopy == 3'b000) |=> (copyQ[0] == copyQ[1] && copyQ[1] == copyQ[2])); // R2

  AST_MASK_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> !strb.cmpEn);                                              // R5

endmodule

// File: rtl/seuMonData.sv
module seuMonData
  import seuMonPkg::*;
#(
  parameter int SR_LEN = 16,
  parameter int NUM_SR = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [NUM_SR-1:0] hitReg,
  output logic [NUM_SR-2:0] pairErr,
  output logic [NUM_SR-1:0] statusCode
);

  localparam int NUM_PAIR = NUM_SR - 1;

  logic [SR_LEN-1:0]   shiftQ [NUM_SR];
  logic [NUM_SR-1:0]   tapBit;
  logic [NUM_PAIR-1:0] pairDiff;
  logic [NUM_PAIR-1:0] errQ;
  logic                trigErr;
  logic [NUM_SR-1:0]   statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_SR; k++) shiftQ[k] <= '0;
    end else if (strb.clear) begin
      for (int k = 0; k < NUM_SR; k++) shiftQ[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_SR; k++)
        shiftQ[k] <= {shiftQ[k][SR_LEN-2:0], strb.dataBit ^ hitReg[k]};
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SR; g++) begin : gTap
      assign tapBit[g] = shiftQ[g][SR_LEN-1];
    end
    for (g = 0; g < NUM_PAIR; g++) begin : gPair
      assign pairDiff[g] = tapBit[g] ^ tapBit[g+1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ    <= '0;
      trigErr <= 1'b0;
      statusQ <= '0;
    end else if (strb.clear) begin
      errQ    <= '0;
      trigErr <= 1'b0;
      statusQ <= '0;
    end else begin
      if (strb.cmpEn) errQ <= errQ | pairDiff;
      if (strb.trigBad) trigErr <= 1'b1;
      statusQ <= {errQ, trigErr};
    end
  end

  assign pairErr    = errQ;
  assign statusCode = statusQ;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> ((errQ & $past(errQ)) == $past(errQ)));            // R6

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cmpEn && !strb.clear) |=> (errQ == $past(errQ)));           // R5

  AST_STATUS_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~{errQ, trigErr}) == '0));                             // R8

endmodule

// File: rtl/seuShiftMonitor.sv
module seuShiftMonitor
  import seuMonPkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int SR_LEN   = 16,
  parameter int NUM_SR   = 4,
  parameter int DATA_TAP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic [2:0]        hitCopy,
  input  logic [NUM_SR-1:0] hitReg,
  output logic              trig,
  output logic [NUM_SR-2:0] pairErr,
  output logic [NUM_SR-1:0] statusCode
);

  strobe_t strb;

  seuMonCtrl #(
    .CNT_W(CNT_W), .SR_LEN(SR_LEN), .DATA_TAP(DATA_TAP)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .clr(clr), .hitCopy(hitCopy),
    .trig(trig), .strb(strb)
  );

  seuMonData #(
    .SR_LEN(SR_LEN), .NUM_SR(NUM_SR)
  ) dataInst (
    .clk(clk), .rstN(rstN), .strb(strb), .hitReg(hitReg),
    .pairErr(pairErr), .statusCode(statusCode)
  );

endmodule

// File: tb/test_seuShiftMonitor.sv
module test_seuShiftMonitor;

  localparam int CNT_W    = 8;
  localparam int SR_LEN   = 16;
  localparam int NUM_SR   = 4;
  localparam int DATA_TAP = 1;
  localparam int MAXV     = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clr = 1'b0;
  logic [2:0] hitCopy = 3'b000;
  logic [3:0] hitReg = 4'b0000;
  logic       trig;
  logic [2:0] pairErr;
  logic [3:0] statusCode;

  seuShiftMonitor #(
    .CNT_W(CNT_W), .SR_LEN(SR_LEN), .NUM_SR(NUM_SR), .DATA_TAP(DATA_TAP)
  ) i_seuShiftMonitor (
    .clk(clk), .rstN(rstN), .clr(clr), .hitCopy(hitCopy), .hitReg(hitReg),
    .trig(trig), .pairErr(pairErr), .statusCode(statusCode)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  int cyc     = 0;
  bit armed   = 0;
  bit done    = 0;

  // Behavioural reference state
  int       mc [3];
  int       mpc;
  int       mmask;
  bit       sq [4][$];
  bit [2:0] mErr;
  bit       mTrigErr;
  bit [3:0] mStatus;
  bit       mTrig;

  int trigCount = 0;
  int lastTrig  = -1;
  int lastGap   = 0;

  task automatic modelReset();
    for (int k = 0; k < 3; k++) mc[k] = 0;
    mpc = 0; mmask = 0; mErr = 3'b000; mTrigErr = 1'b0; mStatus = 4'b0000; mTrig = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sq[k].delete();
      for (int i = 0; i < SR_LEN; i++) sq[k].push_back(1'b0);
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  initial modelReset();

  always @(posedge clk) begin : mdl
    int v;
    bit cmpEn;
    bit [2:0] mis;
    bit din;
    cyc++;
    if (!rstN || clr) begin
      modelReset();
    end else begin
      v = (mc[0] & mc[1]) | (mc[0] & mc[2]) | (mc[1] & mc[2]);
      cmpEn = (mmask == SR_LEN);
      for (int k = 0; k < 3; k++) mis[k] = sq[k][0] ^ sq[k+1][0];
      mStatus = {mErr, mTrigErr};
      if (cmpEn) mErr = mErr | mis;
      if ((v == MAXV) != (mpc == MAXV)) mTrigErr = 1'b1;
      mTrig = (v == MAXV);
      din = ((v >> DATA_TAP) & 1) != 0;
      for (int k = 0; k < 4; k++) begin
        void'(sq[k].pop_front());
        sq[k].push_back(din ^ hitReg[k]);
      end
      for (int k = 0; k < 3; k++) mc[k] = ((v + 1) & MAXV) ^ int'(hitCopy[k]);
      mpc = (mpc + 1) & MAXV;
      if (mmask < SR_LEN) mmask++;
    end
    armed = 1'b1;
  end

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R3", "trig", int'(trig), int'(mTrig));
      chk("R5", "pairErr", int'(pairErr), int'(mErr));
      chk("R8", "statusCode", int'(statusCode), int'(mStatus));
      if (trig) begin
        if (lastTrig >= 0) lastGap = cyc - lastTrig;
        lastTrig = cyc;
        trigCount++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog all requirements actual=%0d expected<=200000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic pulseCopy(input logic [2:0] m);
    @(negedge clk) hitCopy = m;
    @(negedge clk) hitCopy = 3'b000;
  endtask

  task automatic pulseReg(input logic [3:0] m);
    @(negedge clk) hitReg = m;
    @(negedge clk) hitReg = 4'b0000;
  endtask

  task automatic doClear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "trig after reset", int'(trig), 0);
    chk("R1", "pairErr after reset", int'(pairErr), 0);
    chk("R1", "statusCode after reset", int'(statusCode), 0);

    trigCount = 0;
    repeat (600) @(negedge clk);
    chk("R3", "trig pulses in 600 clocks", trigCount, 2);
    chk("R3", "trig spacing", lastGap, 256);

    // R2: single copies corrupted one at a time
    pulseCopy(3'b001);
    repeat (50) @(negedge clk);
    pulseCopy(3'b010);
    repeat (50) @(negedge clk);
    pulseCopy(3'b100);
    repeat (600) @(negedge clk);
    chk("R2", "status after single-copy hits", int'(statusCode), 0);
    chk("R2", "trig spacing after single-copy hits", lastGap, 256);
    chk("R4", "no flag on clean stream", int'(pairErr), 0);

    // R5: inject into register 0 on the first edge after a clear
    @(negedge clk) clr = 1'b1;
    @(negedge clk) begin clr = 1'b0; hitReg = 4'b0001; end
    @(negedge clk) hitReg = 4'b0000;
    repeat (15) @(negedge clk);
    chk("R5", "pairErr one edge before due", int'(pairErr), 0);
    @(negedge clk);
    chk("R5", "pairErr at due edge", int'(pairErr), 1);
    chk("R8", "status lags flag", int'(statusCode), 0);
    @(negedge clk);
    chk("R8", "status after flag", int'(statusCode), 4'b0010);
    repeat (300) @(negedge clk);
    chk("R6", "flag sticky", int'(pairErr), 1);

    pulseReg(4'b0010);
    repeat (20) @(negedge clk);
    chk("R5", "register 1 hit sets pairs 0 and 1", int'(pairErr), 3'b011);
    pulseReg(4'b1000);
    repeat (20) @(negedge clk);
    chk("R8", "status with all pair flags", int'(statusCode), 4'b1110);

    // R1: clear wins over simultaneous injection
    @(negedge clk) begin clr = 1'b1; hitReg = 4'b1111; hitCopy = 3'b111; end
    @(negedge clk) begin clr = 1'b0; hitReg = 4'b0000; hitCopy = 3'b000; end
    chk("R1", "pairErr after clear", int'(pairErr), 0);
    chk("R1", "statusCode after clear", int'(statusCode), 0);
    repeat (600) @(negedge clk);
    chk("R1", "injection during clear ignored", int'(statusCode), 0);

    // R7: two copies corrupted together derail the count
    pulseCopy(3'b011);
    repeat (600) @(negedge clk);
    chk("R7", "heartbeat failure only", int'(statusCode), 4'b0001);

    pulseReg(4'b1001);
    repeat (20) @(negedge clk);
    chk("R8", "status pairs 0 and 2 plus heartbeat", int'(statusCode), 4'b1011);
    pulseReg(4'b0100);
    repeat (20) @(negedge clk);
    chk("R8", "last error code", int'(statusCode), 4'b1111);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule